// File: doc/BRIEF.md
# Four-Channel Pulse Generator with One-Shot Mode

The block drives four pulse outputs from a single shared up-counter. A prescaler divides the system clock by one of eight powers of two, and each divided tick advances the counter. The counter runs from 0 up to a programmable top value and then wraps, so one period lasts `period_max + 1` ticks. Each channel has its own enable, its own inversion control, and its own window. A window is given by a start compare value and a stop compare value. An enabled channel is active while the count lies inside its window.

The `run` level starts and stops the block. While `run` is high, the block runs either continuously or in one-shot mode. In one-shot mode it completes `shot_cycles + 1` periods, then halts with `done` set. Dropping `run` clears all state, so a new burst can begin.

Compare values that fall outside the period give fixed results. If the stop value is past the top value, the channel never turns off before the wrap. If the start value is past the top value, the channel never turns on.

Top module: `pwm_quad_gen`

## Requirements
- R1: After reset, with `run` low, `count` is 0, `done` is 0 and every output equals its `ch_invert` bit.
- R2: While running, `count` advances once every 2^`div_sel` clock cycles. `div_sel` is 3 bits wide, so the division ranges from 1 to 128.
- R3: `count` steps 0, 1, …, `period_max`, then returns to 0 on the next tick.
- R4: An enabled channel n is active exactly when `start_n <= count < stop_n`. Channel n uses bits [10n+9:10n] of `ch_start` and `ch_stop`.
- R5: `pwm_out[n]` equals the active state XOR `ch_invert[n]`. The idle level is therefore `ch_invert[n]`.
- R6: A channel whose `ch_enable` bit is 0 stays at its idle level.
- R7: If `stop_n > period_max`, the channel stays active from `start_n` through `period_max`. With `start_n` equal to 0, it is active on every cycle while running.
- R8: If `start_n > period_max`, the channel never becomes active.
- R9: With `oneshot` set to 1, the block runs `shot_cycles + 1` full periods. It then sets `done`, holds `count` at 0, and returns all outputs to idle until `run` falls.
- R10: With `oneshot` set to 0, `done` never rises.
- R11: With `run` low, the prescaler, `count`, the period tally and `done` are cleared on the next edge, and the outputs sit at idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Level enable; low clears the block |
| oneshot | input | 1 | 1 = burst of `shot_cycles+1` periods, 0 = continuous |
| div_sel | input | 3 | Prescaler select, division 2^div_sel |
| period_max | input | 10 | Top value of the shared counter |
| shot_cycles | input | 10 | One-shot period count minus one |
| ch_enable | input | 4 | Per-channel enable |
| ch_invert | input | 4 | Per-channel polarity inversion |
| ch_start | input | 40 | Packed start compare values, 10 bits per channel |
| ch_stop | input | 40 | Packed stop compare values, 10 bits per channel |
| pwm_out | output | 4 | Channel outputs |
| done | output | 1 | One-shot burst finished |
| count | output | 10 | Current shared counter value |

## Verification
The counter, the prescaler and `done` are registered. Their new values appear one clock edge after the edge that samples the tick. The outputs are combinational from `count` and the configuration, so they follow `count` in the same cycle.

The bench keeps a cycle model that it steps on every rising edge, using the inputs it drove at the previous falling edge. It compares all outputs at each falling edge and only then drives new inputs. The directed cases use edge counts worked out by hand. For example, a one-shot burst at division 2 with top value 3 and `shot_cycles` 1 sets `done` on exactly the 16th edge after `run` rises.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int SEL_W = 3;
  localparam int PRE_W = (1 << SEL_W) - 1;

  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) if (i < int'(sel)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic in_window(input logic [9:0] c, input logic [9:0] lo,
                                     input logic [9:0] hi);
    return (c >= lo) && (c < hi);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_quad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(sel);
  assign tick = adv && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) pre_q <= '0;
    else if (adv)      pre_q <= pre_q + 1'b1;
  end

  // R2
  tick_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && !clr && $stable(sel)) |=> !tick);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          oneshot,
  input  logic          tick,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] shots,
  output logic [CW-1:0] cnt_q,
  output logic          halt_q,
  output logic          live,
  output logic          wrap_ev
);
  logic [CW-1:0] per_q;

  assign live    = run && !halt_q;
  assign wrap_ev = live && tick && (cnt_q >= top);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q  <= '0;
      per_q  <= '0;
      halt_q <= 1'b0;
    end else if (live && tick) begin
      if (wrap_ev) begin
        cnt_q <= '0;
        if (oneshot) begin
          if (per_q >= shots) halt_q <= 1'b1;
          else                per_q  <= per_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev) |=> cnt_q == '0);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !tick) |=> $stable(cnt_q));
  // R9
  halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> cnt_q == '0);
  // R10
  cont_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !oneshot && !halt_q) |=> !halt_q);
  // R11
  run_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !halt_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_quad_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  input  logic          en,
  input  logic          inv,
  output logic          out
);
  logic act;

  assign act = live && en && in_window(cnt, lo, hi);
  assign out = act ^ inv;

  // R8
  start_beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo > top && cnt <= top) |-> out == inv);
  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> out == inv);
  // R7
  stop_beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && en && hi > top && cnt >= lo && cnt <= top) |-> out == !inv);
endmodule

// File: rtl/pwm_quad_gen.sv
module pwm_quad_gen
  import pwm_quad_pkg::*;
#(
  parameter int CH = 4,
  parameter int CW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             oneshot,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [CW-1:0]    period_max,
  input  logic [CW-1:0]    shot_cycles,
  input  logic [CH-1:0]    ch_enable,
  input  logic [CH-1:0]    ch_invert,
  input  logic [CH*CW-1:0] ch_start,
  input  logic [CH*CW-1:0] ch_stop,
  output logic [CH-1:0]    pwm_out,
  output logic             done,
  output logic [CW-1:0]    count
);
  logic tick, live, halt_q, wrap_ev;
  logic [CW-1:0] cnt_q;

  pwm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!run), .adv(live), .sel(div_sel), .tick(tick)
  );

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .oneshot(oneshot), .tick(tick),
    .top(period_max), .shots(shot_cycles), .cnt_q(cnt_q), .halt_q(halt_q),
    .live(live), .wrap_ev(wrap_ev)
  );

  for (genvar g = 0; g < CH; g++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .live(live), .cnt(cnt_q), .top(period_max),
      .lo(ch_start[g*CW +: CW]), .hi(ch_stop[g*CW +: CW]),
      .en(ch_enable[g]), .inv(ch_invert[g]), .out(pwm_out[g])
    );
  end

  assign done  = halt_q;
  assign count = cnt_q;

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pwm_out == ch_invert);
  // R1
  idle_run_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pwm_out == ch_invert);
  // R3
  wrap_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && !oneshot) |=> (count == '0 && !done));
endmodule

// File: tb/pwm_quad_gen_tb.sv
module pwm_quad_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 4;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, oneshot = 1'b0;
  logic [2:0] div_sel = '0;
  logic [CW-1:0] period_max = '0, shot_cycles = '0;
  logic [CH-1:0] ch_enable = '0, ch_invert = '0;
  logic [CH*CW-1:0] ch_start = '0, ch_stop = '0;
  logic [CH-1:0] pwm_out;
  logic done;
  logic [CW-1:0] count;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit over = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_quad_gen dut_i (.*);

  // independent cycle model
  int m_pre = 0, m_cnt = 0, m_per = 0;
  bit m_halt = 1'b0;

  function automatic bit m_tick(int pre, int sel);
    return (pre % (1 << sel)) == ((1 << sel) - 1);
  endfunction

  function automatic logic [CH-1:0] m_out();
    logic [CH-1:0] r;
    for (int n = 0; n < CH; n++) begin
      int lo, hi;
      bit on;
      lo = int'(ch_start[n*CW +: CW]);
      hi = int'(ch_stop[n*CW +: CW]);
      on = run && !m_halt && ch_enable[n] && !(m_cnt < lo) && !(m_cnt >= hi);
      r[n] = on ? !ch_invert[n] : ch_invert[n];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !run) begin
      m_pre = 0; m_cnt = 0; m_per = 0; m_halt = 1'b0;
    end else if (!m_halt) begin
      if (m_tick(m_pre, int'(div_sel))) begin
        if (m_cnt >= int'(period_max)) begin
          m_cnt = 0;
          if (oneshot) begin
            if (m_per >= int'(shot_cycles)) m_halt = 1'b1;
            else m_per++;
          end
        end else m_cnt++;
      end
      m_pre = (m_pre + 1) % 128;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R4/R5 pwm_out vs model (R6 R7 R8)", int'(pwm_out), int'(m_out()));
    chk("R9 done vs model (R10)", int'(done), int'(m_halt));
    chk("R3 count vs model (R2 R11)", int'(count), m_cnt);
  endtask

  task automatic step(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cmp_model();
    end
  endtask

  task automatic finish_up();
    if (!over) begin
      over = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    finish_up();
  end

  initial begin
    bit seen_low, seen_high;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 outputs idle", int'(pwm_out), 0);

    // R9 one-shot: div 2, top 3, shot_cycles 1 -> done on edge 16
    oneshot = 1; div_sel = 1; period_max = 3; shot_cycles = 1;
    ch_enable = 4'hF; ch_invert = 4'b0101;
    ch_start = {10'd0, 10'd1, 10'd2, 10'd0};
    ch_stop  = {10'd4, 10'd3, 10'd3, 10'd2};
    run = 1;
    step(15);
    chk("R9 done not yet after 15 edges", int'(done), 0);
    step(1);
    chk("R9 done after 16 edges", int'(done), 1);
    chk("R9 outputs idle when done", int'(pwm_out), 4'b0101);
    step(5);
    chk("R9 count held at 0", int'(count), 0);
    run = 0; step(1);
    chk("R11 done cleared", int'(done), 0);

    // R2 prescaler: div 8 -> 5 ticks in 40 edges
    oneshot = 0; div_sel = 3; period_max = 1023; run = 1;
    step(40);
    chk("R2 count after 40 edges at div 8", int'(count), 5);
    run = 0; step(1);

    // R7 stop beyond top, start 0: held active; R8 start beyond top: never
    div_sel = 0; period_max = 5; ch_invert = 0; ch_enable = 4'b0011;
    ch_start = {10'd0, 10'd0, 10'd9, 10'd0};
    ch_stop  = {10'd3, 10'd3, 10'd12, 10'd1000};
    run = 1;
    seen_low = 0; seen_high = 0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (!pwm_out[0]) seen_low = 1;
      if (pwm_out[1]) seen_high = 1;
    end
    chk("R7 stop past top never drops", int'(seen_low), 0);
    chk("R8 start past top never rises", int'(seen_high), 0);
    chk("R6 disabled channels idle", int'(pwm_out[3:2]), 0);
    chk("R10 continuous never done", int'(done), 0);
    run = 0; step(1);

    // random segments
    for (int s = 0; s < 60; s++) begin
      oneshot = $urandom_range(0, 1);
      div_sel = 3'($urandom_range(0, 3));
      period_max = 10'($urandom_range(0, 15));
      shot_cycles = 10'($urandom_range(0, 3));
      ch_enable = 4'($urandom);
      ch_invert = 4'($urandom);
      for (int n = 0; n < CH; n++) begin
        ch_start[n*CW +: CW] = 10'($urandom_range(0, 20));
        ch_stop[n*CW +: CW]  = 10'($urandom_range(0, 20));
      end
      run = 1;
      step($urandom_range(20, 400));
      run = 0;
      step(2);
    end
    finish_up();
  end
endmodule